// File: doc/BRIEF.md
# BCD Calendar Clock with Hundredths

This block keeps time of day and calendar date from a 100 Hz tick strobe. Every field is held in packed BCD: hundredths of a second, seconds, minutes, hours, day of week, date of month, month and two-digit year. Hours run either in 24-hour form or in 12-hour form with a PM flag. The date wraps at the true length of each month, and February gains a 29th day in leap years.

Two copies of the time exist. A working set of counters advances on each tick. A host-visible set is what the register port reads. On each tick, the visible set takes the freshly incremented working values, all fields in the same edge. A hold bit in a control byte stops that transfer so that software can read several fields without a carry slipping in between. The working counters keep running while the hold bit is set.

A host write to a time field loads both copies at once. Counting then continues from the written hundredths value.

Top module: `rtc_calendar`

## Requirements
- R1: After synchronous reset the clock reads 00:00:00.00 in 24-hour mode, day of week 01, date 01, month 01, year 00, and the control byte reads 00.
- R2: Each tick advances hundredths by one in BCD. The step 99 to 00 carries into seconds, seconds 59 to 00 carries into minutes, and minutes 59 to 00 carries into hours.
- R3: With hours bit 6 clear (24-hour mode), hours count 00 to 23 in BCD, and 23 to 00 carries into the day.
- R4: With hours bit 6 set (12-hour mode), bits 4:0 hold the BCD hour in the sequence 12, 01 to 11, and bit 5 is the PM flag. The step 11 to 12 toggles PM, and only the step from 11 PM to 12 AM carries into the day.
- R5: A day carry steps day of week 1 to 7 and wraps to 1. Month wraps 12 to 01 with a carry into year, and year wraps 99 to 00.
- R6: The date wraps to 01 after 30 in months 04, 06, 09 and 11, and after 31 in months 01, 03, 05, 07, 08, 10 and 12.
- R7: In month 02 the date wraps after 29 when the BCD year is divisible by 4, and after 28 otherwise.
- R8: Register indices are 0 hundredths, 1 seconds, 2 minutes, 4 hours, 6 day of week, 8 date, 9 month, A year and B control. Read data appears on rd_data one clock after the index is presented. Indices 3, 5, 7 and C to F read 00, and writes to them change nothing.
- R9: A write to a time field is readable at the next access and loads the working copy too, so counting continues from the written value. A tick that arrives in a write cycle is dropped.
- R10: With hold clear, every tick updates the visible copies in the same edge as the working counters, so a read right after a tick shows the new time.
- R11: Control bit 0 is the hold. While it is 1, reads return the values frozen at the moment it was set, apart from fields written since, and the working time keeps advancing. After it is cleared, the next tick makes the visible copies current. The control byte reads back with only bit 0 significant.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| tick | input | 1 | One-cycle 100 Hz strobe |
| wr_en | input | 1 | Register write strobe |
| addr | input | 4 | Register index for reads and writes |
| wr_data | input | 8 | Write data |
| rd_data | output | 8 | Registered read data for the previous cycle's index |

## Verification
The assertions assume that the host writes only legal BCD values: a date that exists in the current month, an hour that fits the selected mode, and a day of week from 1 to 7. The bench draws random times only from those legal ranges, skewing hundredths and seconds toward their rollover values. Directed cases cover each month-end, February in leap and common years, and every 12-hour transition. The bench never pulses tick in the same cycle as a write, except in the one case that checks the tick is dropped.

// File: rtl/rtc_pkg.sv
package rtc_pkg;
  localparam int DATA_W   = 8;
  localparam int ADDR_W   = 4;
  localparam int FIELDS   = 8;
  localparam logic [ADDR_W-1:0] CTRL_IDX = 4'hB;
  localparam int HOLD_BIT  = 0;
  localparam int MODE12_BIT = 6;
  localparam int PM_BIT     = 5;

  // field order matches the packed layout: field i is bits [8*i +: 8]
  typedef struct packed {
    logic [DATA_W-1:0] year;
    logic [DATA_W-1:0] month;
    logic [DATA_W-1:0] date;
    logic [DATA_W-1:0] dow;
    logic [DATA_W-1:0] hour;
    logic [DATA_W-1:0] min;
    logic [DATA_W-1:0] sec;
    logic [DATA_W-1:0] hund;
  } rtc_time_t;

  localparam rtc_time_t RESET_TIME = '{year: 8'h00, month: 8'h01, date: 8'h01,
                                       dow: 8'h01, hour: 8'h00, min: 8'h00,
                                       sec: 8'h00, hund: 8'h00};

  function automatic logic [ADDR_W-1:0] field_addr(input int i);
    case (i)
      0: return 4'h0;
      1: return 4'h1;
      2: return 4'h2;
      3: return 4'h4;
      4: return 4'h6;
      5: return 4'h8;
      6: return 4'h9;
      default: return 4'hA;
    endcase
  endfunction

  function automatic logic [7:0] bcd_inc(input logic [7:0] v);
    if (v[3:0] == 4'd9) return {v[7:4] + 4'd1, 4'd0};
    return {v[7:4], v[3:0] + 4'd1};
  endfunction

  // divisible by 4: even tens with units 0/4/8, odd tens with units 2/6
  function automatic logic is_leap(input logic [7:0] y);
    if (y[4]) return (y[3:0] == 4'd2) || (y[3:0] == 4'd6);
    return (y[3:0] == 4'd0) || (y[3:0] == 4'd4) || (y[3:0] == 4'd8);
  endfunction

  function automatic logic [7:0] month_len(input logic [7:0] mo, input logic leap);
    case (mo)
      8'h02: return leap ? 8'h29 : 8'h28;
      8'h04, 8'h06, 8'h09, 8'h11: return 8'h30;
      default: return 8'h31;
    endcase
  endfunction
endpackage

// File: rtl/rtc_advance.sv
module rtc_advance
  import rtc_pkg::*;
(
  input  rtc_time_t cur,
  output rtc_time_t nxt
);
  logic       carry;
  logic [7:0] h12_inc;

  assign h12_inc = bcd_inc({3'b000, cur.hour[4:0]});

  always_comb begin
    nxt   = cur;
    carry = 1'b0;
    // hundredths
    if (cur.hund == 8'h99) begin
      nxt.hund = 8'h00;
      carry    = 1'b1;
    end else begin
      nxt.hund = bcd_inc(cur.hund);
    end
    // seconds
    if (carry) begin
      if (cur.sec == 8'h59) begin
        nxt.sec = 8'h00;
      end else begin
        nxt.sec = bcd_inc(cur.sec);
        carry   = 1'b0;
      end
    end
    // minutes
    if (carry) begin
      if (cur.min == 8'h59) begin
        nxt.min = 8'h00;
      end else begin
        nxt.min = bcd_inc(cur.min);
        carry   = 1'b0;
      end
    end
    // hours
    if (carry) begin
      carry = 1'b0;
      if (cur.hour[MODE12_BIT]) begin
        if (cur.hour[4:0] == 5'h11) begin
          nxt.hour[4:0]    = 5'h12;
          nxt.hour[PM_BIT] = ~cur.hour[PM_BIT];
          carry            = cur.hour[PM_BIT];
        end else if (cur.hour[4:0] == 5'h12) begin
          nxt.hour[4:0] = 5'h01;
        end else begin
          nxt.hour[4:0] = h12_inc[4:0];
        end
      end else if (cur.hour[5:0] == 6'h23) begin
        nxt.hour[5:0] = 6'h00;
        carry         = 1'b1;
      end else begin
        nxt.hour[5:0] = bcd_inc({2'b00, cur.hour[5:0]})[5:0];
      end
    end
    // day of week, date, month, year
    if (carry) begin
      nxt.dow = (cur.dow == 8'h07) ? 8'h01 : bcd_inc(cur.dow);
      if (cur.date == month_len(cur.month, is_leap(cur.year))) begin
        nxt.date = 8'h01;
        if (cur.month == 8'h12) begin
          nxt.month = 8'h01;
          nxt.year  = (cur.year == 8'h99) ? 8'h00 : bcd_inc(cur.year);
        end else begin
          nxt.month = bcd_inc(cur.month);
        end
      end else begin
        nxt.date = bcd_inc(cur.date);
      end
    end
  end
endmodule

// File: rtl/rtc_counter.sv
module rtc_counter
  import rtc_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              tick,
  input  logic              wr_en,
  input  logic [FIELDS-1:0] field_hit,
  input  logic [DATA_W-1:0] wr_data,
  input  rtc_time_t         nxt,
  output rtc_time_t         cur
);
  always_ff @(posedge clk) begin
    if (rst) begin
      cur <= RESET_TIME;
    end else if (wr_en) begin
      for (int i = 0; i < FIELDS; i++) begin
        if (field_hit[i]) cur[DATA_W*i +: DATA_W] <= wr_data;
      end
    end else if (tick) begin
      cur <= nxt;
    end
  end

  // R9: the working copy is loaded by a host write
  a_r9_hund_load: assert property (@(posedge clk) disable iff (rst)
    field_hit[0] |=> cur.hund == $past(wr_data));

  // R2: counters stay still without a tick or write
  a_r2_idle_stable: assert property (@(posedge clk) disable iff (rst)
    (!tick && !wr_en) |=> $stable(cur));

  // R2: hundredths wrap clears to zero
  a_r2_hund_wrap: assert property (@(posedge clk) disable iff (rst)
    (tick && !wr_en && cur.hund == 8'h99) |=> cur.hund == 8'h00);

  // R6: the date never leaves its legal range
  a_r6_date_legal: assert property (@(posedge clk) disable iff (rst)
    (cur.date != 8'h00) && (cur.date <= 8'h31));
endmodule

// File: rtl/rtc_visible.sv
module rtc_visible
  import rtc_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              xfer,
  input  logic [FIELDS-1:0] field_hit,
  input  logic [DATA_W-1:0] wr_data,
  input  rtc_time_t         nxt,
  input  logic [ADDR_W-1:0] addr,
  input  logic              hold,
  output rtc_time_t         vis,
  output logic [DATA_W-1:0] rd_data
);
  logic [DATA_W-1:0] rd_sel;
  logic              mapped;

  always_ff @(posedge clk) begin
    if (rst) begin
      vis <= RESET_TIME;
    end else begin
      for (int i = 0; i < FIELDS; i++) begin
        if (field_hit[i])
          vis[DATA_W*i +: DATA_W] <= wr_data;
        else if (xfer)
          vis[DATA_W*i +: DATA_W] <= nxt[DATA_W*i +: DATA_W];
      end
    end
  end

  always_comb begin
    rd_sel = '0;
    mapped = 1'b0;
    for (int i = 0; i < FIELDS; i++) begin
      if (addr == field_addr(i)) begin
        rd_sel = vis[DATA_W*i +: DATA_W];
        mapped = 1'b1;
      end
    end
    if (addr == CTRL_IDX) begin
      rd_sel           = '0;
      rd_sel[HOLD_BIT] = hold;
      mapped           = 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) rd_data <= '0;
    else     rd_data <= rd_sel;
  end

  // R11: with no transfer and no write, the visible copies stay frozen
  a_r11_frozen: assert property (@(posedge clk) disable iff (rst)
    (!xfer && field_hit == '0) |=> $stable(vis));

  // R8: unmapped indices read zero one cycle later
  a_r8_unmapped_zero: assert property (@(posedge clk) disable iff (rst)
    !mapped |=> rd_data == '0);
endmodule

// File: rtl/rtc_calendar.sv
module rtc_calendar
  import rtc_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              tick,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wr_data,
  output logic [DATA_W-1:0] rd_data
);
  rtc_time_t         cur;
  rtc_time_t         nxt;
  rtc_time_t         vis;
  logic [FIELDS-1:0] field_hit;
  logic              hold_q;
  logic              xfer;

  for (genvar g = 0; g < FIELDS; g++) begin : g_decode
    localparam logic [ADDR_W-1:0] IDX = field_addr(g);
    assign field_hit[g] = wr_en && (addr == IDX);
  end

  assign xfer = tick && !wr_en && !hold_q;

  always_ff @(posedge clk) begin
    if (rst)                              hold_q <= 1'b0;
    else if (wr_en && addr == CTRL_IDX)   hold_q <= wr_data[HOLD_BIT];
  end

  rtc_advance u_adv (
    .cur (cur),
    .nxt (nxt)
  );

  rtc_counter u_cnt (
    .clk       (clk),
    .rst       (rst),
    .tick      (tick),
    .wr_en     (wr_en),
    .field_hit (field_hit),
    .wr_data   (wr_data),
    .nxt       (nxt),
    .cur       (cur)
  );

  rtc_visible u_vis (
    .clk       (clk),
    .rst       (rst),
    .xfer      (xfer),
    .field_hit (field_hit),
    .wr_data   (wr_data),
    .nxt       (nxt),
    .addr      (addr),
    .hold      (hold_q),
    .vis       (vis),
    .rd_data   (rd_data)
  );

  // R10: an unheld tick leaves both copies equal
  a_r10_copy: assert property (@(posedge clk) disable iff (rst)
    xfer |=> vis == cur);

  // R9: a write cycle swallows a coincident tick for the hundredths of both copies
  a_r9_write_wins: assert property (@(posedge clk) disable iff (rst)
    (tick && field_hit[0]) |=> (vis.hund == $past(wr_data)) && (cur.hund == $past(wr_data)));
endmodule

// File: tb/rtc_calendar_bench.sv
`timescale 1ns/1ps
module rtc_calendar_bench;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       tick = 1'b0;
  logic       wr_en = 1'b0;
  logic [3:0] addr = 4'h0;
  logic [7:0] wr_data = 8'h00;
  logic [7:0] rd_data;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  // bench model in binary
  int h100, s, mi, hr, pm, m12, dw, dt, mo, yr;
  logic [7:0] snap [8];

  always #5 clk = ~clk;

  rtc_calendar u_rtc_calendar (
    .clk(clk), .rst(rst), .tick(tick), .wr_en(wr_en),
    .addr(addr), .wr_data(wr_data), .rd_data(rd_data)
  );

  function automatic logic [7:0] to_bcd(input int v);
    return 8'((v / 10) * 16 + (v % 10));
  endfunction

  function automatic logic [3:0] reg_of(input int i);
    logic [3:0] t [8] = '{4'h0, 4'h1, 4'h2, 4'h4, 4'h6, 4'h8, 4'h9, 4'hA};
    return t[i];
  endfunction

  function automatic logic [7:0] mbyte(input int i);
    case (i)
      0: return to_bcd(h100);
      1: return to_bcd(s);
      2: return to_bcd(mi);
      3: return m12 ? (8'h40 | (pm ? 8'h20 : 8'h00) | to_bcd(hr)) : to_bcd(hr);
      4: return to_bcd(dw);
      5: return to_bcd(dt);
      6: return to_bcd(mo);
      default: return to_bcd(yr);
    endcase
  endfunction

  function automatic int days_of(input int m, input int y);
    if (m == 2) return (y % 4 == 0) ? 29 : 28;
    if (m == 4 || m == 6 || m == 9 || m == 11) return 30;
    return 31;
  endfunction

  task automatic m_adv();
    bit day = 0;
    h100++;
    if (h100 < 100) return;
    h100 = 0; s++;
    if (s < 60) return;
    s = 0; mi++;
    if (mi < 60) return;
    mi = 0;
    if (m12) begin
      if (hr == 11) begin hr = 12; pm = !pm; day = (pm == 0); end
      else if (hr == 12) hr = 1;
      else hr++;
    end else begin
      hr++;
      if (hr == 24) begin hr = 0; day = 1; end
    end
    if (!day) return;
    dw = (dw == 7) ? 1 : dw + 1;
    if (dt == days_of(mo, yr)) begin
      dt = 1; mo++;
      if (mo == 13) begin mo = 1; yr = (yr + 1) % 100; end
    end else dt++;
  endtask

  task automatic cyc(input logic t, input logic w, input logic [3:0] a, input logic [7:0] d);
    @(negedge clk);
    tick = t; wr_en = w; addr = a; wr_data = d;
  endtask

  task automatic expect_reg(input logic [3:0] a, input logic [7:0] exp, input string req);
    cyc(1'b0, 1'b0, a, 8'h00);
    @(posedge clk); #1;
    checks++;
    if (rd_data !== exp) begin
      failures++;
      $display("FAIL %s idx=%0h got=%02h exp=%02h", req, a, rd_data, exp);
    end
  endtask

  task automatic check_all(input string req);
    for (int i = 0; i < 8; i++) expect_reg(reg_of(i), mbyte(i), req);
  endtask

  task automatic load_model();
    for (int i = 0; i < 8; i++) cyc(1'b0, 1'b1, reg_of(i), mbyte(i));
  endtask

  task automatic ticks(input int n);
    for (int k = 0; k < n; k++) begin
      cyc(1'b1, 1'b0, 4'h0, 8'h00);
      m_adv();
    end
  endtask

  task automatic set_time(input int a_m12, input int a_pm, input int a_hr, input int a_mi,
                          input int a_s, input int a_h100, input int a_dw, input int a_dt,
                          input int a_mo, input int a_yr);
    m12 = a_m12; pm = a_pm; hr = a_hr; mi = a_mi; s = a_s; h100 = a_h100;
    dw = a_dw; dt = a_dt; mo = a_mo; yr = a_yr;
    load_model();
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(posedge clk);
    @(negedge clk) rst = 1'b0;

    // R1 reset state
    m12 = 0; pm = 0; hr = 0; mi = 0; s = 0; h100 = 0; dw = 1; dt = 1; mo = 1; yr = 0;
    check_all("R1");
    expect_reg(4'hB, 8'h00, "R1");

    // R2 / R10: plain counting and carries into minutes
    set_time(0, 0, 5, 58, 59, 97, 3, 10, 6, 21);
    ticks(5);
    check_all("R2");

    // R3 / R5: 23:59:59.99 on the last day of the century
    set_time(0, 0, 23, 59, 59, 99, 7, 31, 12, 99);
    ticks(1);
    check_all("R3");
    expect_reg(4'h6, 8'h01, "R5");
    expect_reg(4'hA, 8'h00, "R5");

    // R4: 12-hour transitions
    set_time(1, 0, 11, 59, 59, 99, 2, 14, 3, 30);
    ticks(1);
    expect_reg(4'h4, 8'h72, "R4");
    expect_reg(4'h8, 8'h14, "R4");
    set_time(1, 1, 12, 59, 59, 99, 2, 14, 3, 30);
    ticks(1);
    expect_reg(4'h4, 8'h61, "R4");
    set_time(1, 1, 11, 59, 59, 99, 2, 14, 3, 30);
    ticks(1);
    expect_reg(4'h4, 8'h52, "R4");
    expect_reg(4'h8, 8'h15, "R4");
    check_all("R4");

    // R6: thirty and thirty-one day months
    set_time(0, 0, 23, 59, 59, 99, 1, 30, 4, 10);
    ticks(1);
    check_all("R6");
    set_time(0, 0, 23, 59, 59, 99, 1, 30, 1, 10);
    ticks(1);
    expect_reg(4'h8, 8'h31, "R6");
    set_time(0, 0, 23, 59, 59, 99, 1, 31, 1, 10);
    ticks(1);
    check_all("R6");

    // R7: February, common and leap
    set_time(0, 0, 23, 59, 59, 99, 1, 28, 2, 23);
    ticks(1);
    check_all("R7");
    set_time(0, 0, 23, 59, 59, 99, 1, 28, 2, 24);
    ticks(1);
    expect_reg(4'h8, 8'h29, "R7");
    ticks(8640000 / 100 > 0 ? 0 : 0);
    set_time(0, 0, 23, 59, 59, 99, 1, 29, 2, 24);
    ticks(1);
    check_all("R7");
    set_time(0, 0, 23, 59, 59, 99, 1, 28, 2, 0);
    ticks(1);
    expect_reg(4'h8, 8'h29, "R7");

    // R8: unmapped indices ignore writes and read zero
    set_time(0, 0, 9, 8, 7, 6, 5, 4, 3, 2);
    cyc(1'b0, 1'b1, 4'h3, 8'h55);
    cyc(1'b0, 1'b1, 4'hD, 8'h77);
    expect_reg(4'h3, 8'h00, "R8");
    expect_reg(4'hD, 8'h00, "R8");
    check_all("R8");

    // R9: tick during a write is dropped; count resumes from written value
    cyc(1'b1, 1'b1, 4'h0, 8'h42);
    h100 = 42;
    expect_reg(4'h0, 8'h42, "R9");
    ticks(3);
    check_all("R9");

    // R11: hold freezes visible copies while time runs
    cyc(1'b0, 1'b1, 4'hB, 8'h01);
    expect_reg(4'hB, 8'h01, "R11");
    for (int i = 0; i < 8; i++) snap[i] = mbyte(i);
    ticks(150);
    for (int i = 0; i < 8; i++) expect_reg(reg_of(i), snap[i], "R11");
    cyc(1'b0, 1'b1, 4'hB, 8'h00);
    expect_reg(4'h1, snap[1], "R11");
    ticks(1);
    check_all("R11");

    // random legal times with runs of ticks
    for (int it = 0; it < 30; it++) begin
      int a_m12, a_hr, a_mo, a_yr;
      a_m12 = $urandom % 2;
      a_hr  = a_m12 ? 1 + $urandom % 12 : $urandom % 24;
      a_mo  = 1 + $urandom % 12;
      a_yr  = $urandom % 100;
      set_time(a_m12, $urandom % 2, a_hr, ($urandom % 2) ? 59 : $urandom % 60,
               ($urandom % 2) ? 59 : $urandom % 60, ($urandom % 2) ? 99 : $urandom % 100,
               1 + $urandom % 7, 1 + $urandom % days_of(a_mo, a_yr), a_mo, a_yr);
      ticks(1 + $urandom % 400);
      check_all("R10");
    end

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule